// File: doc/BRIEF.md
# NAND Management Command Sequencer

This block runs the housekeeping command sequences of an 8-bit NAND flash device. None of them programs the array. A host picks an operation with a 3-bit code, gives a byte count where one applies, and pulses `start`. The sequencer then does the following:

- It drives the command-latch and address-latch cycles with a write-enable pulse of its own.
- It waits the turnaround or ready time that the operation needs.
- It clocks out read bytes with read-enable pulses.
- It hands each byte it reads to the host with a one-cycle valid strobe.

The sequencer covers eight operations: the two reset flavours, the identifier read, the signature read, the parameter page, the unique identifier, the one-time-programmable area lock and the special page read. All timing is in clock cycles and set by parameters. A ready wait that lasts too long ends the operation with an error flag. The sequencer does not interpret the bytes it reads.

Top module: `nand_mgmt_seq`

## Requirements
- R1: While and right after `rst_n` is low, `busy`, `done`, `err`, `rd_valid`, `cle`, `ale` and `dq_oe` are 0 and `we_n`, `re_n` are 1.
- R2: Every bus write cycle drives the byte on `dq_out` with `dq_oe` high and exactly one of `cle` (command) or `ale` (address) high. `we_n` is low for T_WP cycles and then high for T_WH cycles, with the byte and latch held. The device latches the byte at the rising edge of `we_n`.
- R3: Operation 0 writes command FFh; operation 1 writes command FCh; both finish with no wait and no read.
- R4: Operation 2 writes command 90h and address 00h, then leaves at least T_WHR cycles before the first `re_n` fall, then reads `rd_count` bytes.
- R5: Operation 3 writes command 90h and address 20h, leaves at least T_WHR cycles, then reads `rd_count` bytes.
- R6: Operation 4 writes command ECh and address 00h, waits for `rb_n` high, leaves at least T_RR cycles after it, then reads `rd_count` bytes.
- R7: Operation 5 writes command EDh and address 00h, leaves at least T_RR cycles after the last write, then reads `rd_count` bytes.
- R8: Operation 6 writes command A5h, then addresses 00h, 00h, 01h, 00h, 00h, then command 10h. It then waits for `rb_n` high and reads nothing.
- R9: Operation 7 writes commands 30h, 65h, 00h, then five addresses, then command 30h. The five addresses are 00h, X, 02h, 00h, 00h, where X is 00h when `page_sel`=1 and 02h when `page_sel`=0. The operation then waits for `rb_n` high, leaves at least T_RR cycles, and reads exactly 256 bytes whatever `rd_count` is.
- R10: Each read byte holds `re_n` low for T_REA cycles. `dq_in` is sampled on the edge where `re_n` returns high, and in the same cycle `rd_data` shows that byte with `rd_valid` high for one cycle. `re_n` and `we_n` are never both low.
- R11: A `rd_count` of 0 makes the read phase of operations 2 to 5 produce no `re_n` pulse.
- R12: If `rb_n` stays low for BUSY_LIMIT cycles of a ready wait, the operation ends with `done` and `err` both high. `err` stays high until the next accepted `start`, which clears it.
- R13: `start` is ignored while `busy` is high and does not alter the running sequence.
- R14: `done` is a single-cycle pulse at the end of each operation, with `busy` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 3 | Operation code (0 to 7) |
| page_sel | input | 1 | Special page choice for operation 7 |
| rd_count | input | CNT_W | Bytes to read for operations 2 to 5 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Ready-wait timeout of the last operation |
| rd_data | output | 8 | Last byte read from the device |
| rd_valid | output | 1 | `rd_data` is new this cycle |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write enable, active low |
| re_n | output | 1 | Read enable, active low |
| dq_out | output | 8 | Byte driven to the device |
| dq_oe | output | 1 | Output enable for `dq_out` |
| dq_in | input | 8 | Byte returned by the device |
| rb_n | input | 1 | Ready/busy from the device, low when busy |

## Verification
The bench sets T_WP=2, T_WH=2, T_WHR=6, T_RR=5, T_REA=3, T_REH=2 and T_WB=2. With these values an omitted turnaround wait visibly shortens the gap between the last write and the first read. Its device model returns 0xEE until `re_n` has been low for T_REA cycles, so a read sampled too early shows up as wrong data. BUSY_LIMIT is lowered to 40, so a 100-cycle busy period reaches the timeout quickly, while normal 10-cycle busy periods stay clear of it.

// File: rtl/nand_mgmt_seq.sv
module nand_mgmt_seq #(
  parameter int CNT_W      = 9,
  parameter int TW         = 16,
  parameter int T_WP       = 2,
  parameter int T_WH       = 2,
  parameter int T_WHR      = 8,
  parameter int T_RR       = 4,
  parameter int T_REA      = 3,
  parameter int T_REH      = 2,
  parameter int T_WB       = 4,
  parameter int BUSY_LIMIT = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic             page_sel,
  input  logic [CNT_W-1:0] rd_count,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       dq_out,
  output logic             dq_oe,
  input  logic [7:0]       dq_in,
  input  logic             rb_n
);

  localparam int LW = (CNT_W > 9) ? CNT_W : 9;

  localparam logic [2:0] K_CMD  = 3'd0;
  localparam logic [2:0] K_ADR  = 3'd1;
  localparam logic [2:0] K_WHR  = 3'd2;
  localparam logic [2:0] K_RR   = 3'd3;
  localparam logic [2:0] K_RDY  = 3'd4;
  localparam logic [2:0] K_RDN  = 3'd5;
  localparam logic [2:0] K_R256 = 3'd6;
  localparam logic [2:0] K_END  = 3'd7;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_WLO, S_WHI, S_WAIT, S_BPRE, S_BSY, S_RLO, S_RHI
  } st_t;

  function automatic logic [10:0] stp(input logic [2:0] o, input logic s, input logic [3:0] i);
    logic [10:0] r;
    r = {K_END, 8'h00};
    case (o)
      3'd0: if (i == 0) r = {K_CMD, 8'hFF};
      3'd1: if (i == 0) r = {K_CMD, 8'hFC};
      3'd2, 3'd3:
        case (i)
          4'd0: r = {K_CMD, 8'h90};
          4'd1: r = {K_ADR, (o == 3'd3) ? 8'h20 : 8'h00};
          4'd2: r = {K_WHR, 8'h00};
          4'd3: r = {K_RDN, 8'h00};
          default: ;
        endcase
      3'd4:
        case (i)
          4'd0: r = {K_CMD, 8'hEC};
          4'd1: r = {K_ADR, 8'h00};
          4'd2: r = {K_RDY, 8'h00};
          4'd3: r = {K_RR,  8'h00};
          4'd4: r = {K_RDN, 8'h00};
          default: ;
        endcase
      3'd5:
        case (i)
          4'd0: r = {K_CMD, 8'hED};
          4'd1: r = {K_ADR, 8'h00};
          4'd2: r = {K_RR,  8'h00};
          4'd3: r = {K_RDN, 8'h00};
          default: ;
        endcase
      3'd6:
        case (i)
          4'd0: r = {K_CMD, 8'hA5};
          4'd1, 4'd2, 4'd4, 4'd5: r = {K_ADR, 8'h00};
          4'd3: r = {K_ADR, 8'h01};
          4'd6: r = {K_CMD, 8'h10};
          4'd7: r = {K_RDY, 8'h00};
          default: ;
        endcase
      default:
        case (i)
          4'd0, 4'd8: r = {K_CMD, 8'h30};
          4'd1: r = {K_CMD, 8'h65};
          4'd2: r = {K_CMD, 8'h00};
          4'd3, 4'd6, 4'd7: r = {K_ADR, 8'h00};
          4'd4: r = {K_ADR, s ? 8'h00 : 8'h02};
          4'd5: r = {K_ADR, 8'h02};
          4'd9: r = {K_RDY, 8'h00};
          4'd10: r = {K_RR, 8'h00};
          4'd11: r = {K_R256, 8'h00};
          default: ;
        endcase
    endcase
    return r;
  endfunction

  st_t             st;
  logic [3:0]      idx;
  logic [TW-1:0]   tmr;
  logic [LW-1:0]   left;
  logic [2:0]      cur_op;
  logic            cur_sel;
  logic [CNT_W-1:0] cur_cnt;
  logic [10:0]     s_now;

  assign s_now = stp(cur_op, cur_sel, idx);
  assign busy  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; tmr <= '0; left <= '0;
      cur_op <= '0; cur_sel <= 1'b0; cur_cnt <= '0;
      done <= 1'b0; err <= 1'b0; rd_data <= '0; rd_valid <= 1'b0;
      cle <= 1'b0; ale <= 1'b0; we_n <= 1'b1; re_n <= 1'b1;
      dq_out <= '0; dq_oe <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cur_op <= op; cur_sel <= page_sel; cur_cnt <= rd_count;
          idx <= '0; err <= 1'b0; st <= S_FETCH;
        end
        S_FETCH: begin
          case (s_now[10:8])
            K_CMD, K_ADR: begin
              cle <= (s_now[10:8] == K_CMD);
              ale <= (s_now[10:8] == K_ADR);
              dq_out <= s_now[7:0]; dq_oe <= 1'b1; we_n <= 1'b0;
              tmr <= TW'(T_WP - 1); st <= S_WLO;
            end
            K_WHR: begin tmr <= TW'(T_WHR - 1); st <= S_WAIT; end
            K_RR:  begin tmr <= TW'(T_RR - 1);  st <= S_WAIT; end
            K_RDY: begin tmr <= TW'(T_WB - 1);  st <= S_BPRE; end
            K_RDN, K_R256: begin
              if (s_now[10:8] == K_RDN && cur_cnt == '0) begin
                idx <= idx + 4'd1;
              end else begin
                left <= (s_now[10:8] == K_R256) ? LW'(256) : LW'(cur_cnt);
                re_n <= 1'b0; tmr <= TW'(T_REA - 1); st <= S_RLO;
              end
            end
            default: begin done <= 1'b1; st <= S_IDLE; end
          endcase
        end
        S_WLO: if (tmr == '0) begin
          we_n <= 1'b1; tmr <= TW'(T_WH - 1); st <= S_WHI;
        end else tmr <= tmr - 1'b1;
        S_WHI: if (tmr == '0) begin
          cle <= 1'b0; ale <= 1'b0; dq_oe <= 1'b0; idx <= idx + 4'd1; st <= S_FETCH;
        end else tmr <= tmr - 1'b1;
        S_WAIT: if (tmr == '0) begin
          idx <= idx + 4'd1; st <= S_FETCH;
        end else tmr <= tmr - 1'b1;
        S_BPRE: if (tmr == '0) begin
          tmr <= '0; st <= S_BSY;
        end else tmr <= tmr - 1'b1;
        S_BSY: if (rb_n) begin
          idx <= idx + 4'd1; st <= S_FETCH;
        end else if (tmr == TW'(BUSY_LIMIT - 1)) begin
          err <= 1'b1; done <= 1'b1; st <= S_IDLE;
        end else tmr <= tmr + 1'b1;
        S_RLO: if (tmr == '0) begin
          rd_data <= dq_in; rd_valid <= 1'b1; re_n <= 1'b1;
          left <= left - 1'b1; tmr <= TW'(T_REH - 1); st <= S_RHI;
        end else tmr <= tmr - 1'b1;
        S_RHI: if (tmr == '0) begin
          if (left == '0) begin
            idx <= idx + 4'd1; st <= S_FETCH;
          end else begin
            re_n <= 1'b0; tmr <= TW'(T_REA - 1); st <= S_RLO;
          end
        end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_one_latch: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  a_r2_oe_with_we: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> (dq_oe && (cle || ale)));
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(!re_n && !we_n));
  a_r10_valid_at_rise: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> (re_n && $past(!re_n)));
  a_r14_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r14_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r12_err_on_done: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> done);
  a_r12_err_idle: assert property (@(posedge clk) disable iff (!rst_n) err |-> !busy);

endmodule

// File: tb/nand_mgmt_seq_tb_top.sv
module nand_mgmt_seq_tb_top;
  localparam int TWP = 2, TWH = 2, TWHR = 6, TRR = 5, TREA = 3, TREH = 2, TWB = 2, BLIM = 40;

  logic clk = 0, rst_n = 0, start = 0, page_sel = 0;
  logic [2:0] op = 0;
  logic [8:0] rd_count = 0;
  logic busy, done, err, rd_valid, cle, ale, we_n, re_n, dq_oe;
  logic [7:0] rd_data, dq_out;
  logic [7:0] dq_in = 8'hEE;
  logic rb_n = 1;

  always #2.5 clk = ~clk;

  nand_mgmt_seq #(.CNT_W(9), .TW(16), .T_WP(TWP), .T_WH(TWH), .T_WHR(TWHR), .T_RR(TRR),
    .T_REA(TREA), .T_REH(TREH), .T_WB(TWB), .BUSY_LIMIT(BLIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .page_sel(page_sel), .rd_count(rd_count),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data), .rd_valid(rd_valid),
    .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .dq_in(dq_in), .rb_n(rb_n));

  function automatic logic [9:0] cw(input logic [7:0] b); return {2'b10, b}; endfunction
  function automatic logic [9:0] aw(input logic [7:0] b); return {2'b01, b}; endfunction

  localparam int NV = 10;
  localparam int OPS [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 7, 2};
  localparam int SEL [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam int CNT [NV] = '{3, 3, 5, 4, 8, 16, 2, 7, 0, 0};
  localparam int NWE [NV] = '{1, 1, 2, 2, 2, 2, 7, 9, 9, 2};
  localparam int BAT [NV] = '{0, 0, 0, 0, 2, 0, 7, 9, 9, 0};
  localparam int NRD [NV] = '{0, 0, 5, 4, 8, 16, 0, 256, 256, 0};
  localparam logic [9:0] WR [NV][13] = '{
    '{cw(8'hFF), 0,0,0,0,0,0,0,0,0,0,0,0},
    '{cw(8'hFC), 0,0,0,0,0,0,0,0,0,0,0,0},
    '{cw(8'h90), aw(8'h00), 0,0,0,0,0,0,0,0,0,0,0},
    '{cw(8'h90), aw(8'h20), 0,0,0,0,0,0,0,0,0,0,0},
    '{cw(8'hEC), aw(8'h00), 0,0,0,0,0,0,0,0,0,0,0},
    '{cw(8'hED), aw(8'h00), 0,0,0,0,0,0,0,0,0,0,0},
    '{cw(8'hA5), aw(8'h00), aw(8'h00), aw(8'h01), aw(8'h00), aw(8'h00), cw(8'h10), 0,0,0,0,0,0},
    '{cw(8'h30), cw(8'h65), cw(8'h00), aw(8'h00), aw(8'h00), aw(8'h02), aw(8'h00), aw(8'h00), cw(8'h30), 0,0,0,0},
    '{cw(8'h30), cw(8'h65), cw(8'h00), aw(8'h00), aw(8'h02), aw(8'h02), aw(8'h00), aw(8'h00), cw(8'h30), 0,0,0,0},
    '{cw(8'h90), aw(8'h00), 0,0,0,0,0,0,0,0,0,0,0}};

  function automatic string tag(input int v);
    case (v)
      0, 1: return "R3";  2: return "R4";  3: return "R5";  4: return "R6";
      5: return "R7";  6: return "R8";  7, 8: return "R9";  default: return "R11";
    endcase
  endfunction

  int total = 0, bad = 0;
  int clr_req = 0, clr_ack = 0;
  int busy_at = 0, busy_len = 10;
  int cyc = 0, nw = 0, nr = 0, rd_bad = 0, ridx = 0, lowcnt = 0, bcnt = 0;
  int last_wr = 0, first_re = -1, rb_rise = 0;
  logic [9:0] wlog [16];
  logic pwe = 1, pcle = 0, pale = 0, pre = 1;
  logic [7:0] pdq = 0;

  always @(negedge clk) begin
    if (clr_req != clr_ack) begin
      clr_ack = clr_req; nw = 0; nr = 0; rd_bad = 0; ridx = 0; first_re = -1;
    end
    if (!pwe && we_n) begin
      if (nw < 16) wlog[nw] = {pcle, pale, pdq};
      nw++; last_wr = cyc;
      if (busy_at != 0 && nw == busy_at) bcnt = busy_len;
    end
    pwe = we_n; pcle = cle; pale = ale; pdq = dq_out;
    if (rd_valid) begin
      if (rd_data !== 8'(8'h40 + nr)) rd_bad++;
      nr++;
    end
    if (!pre && re_n) ridx++;
    if (pre && !re_n && first_re < 0) first_re = cyc;
    if (!re_n) lowcnt++; else lowcnt = 0;
    pre = re_n;
    dq_in = (lowcnt >= TREA) ? 8'(8'h40 + ridx) : 8'hEE;
    if (bcnt > 0) begin rb_n = 0; bcnt--; end
    else begin if (!rb_n) rb_rise = cyc; rb_n = 1; end
    cyc++;
  end

  always @(negedge clk) if (cyc > 150000) begin
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp); end
  endtask

  logic got_done, err_at_done;

  task automatic run_op(input int o, input int s, input int c);
    clr_req++;
    @(negedge clk);
    op = 3'(o); page_sel = s[0]; rd_count = 9'(c); start = 1;
    @(negedge clk); start = 0;
    got_done = 0; err_at_done = 0;
    for (int k = 0; k < 5000; k++) begin
      if (done) begin got_done = 1; err_at_done = err; break; end
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !rd_valid && !cle && !ale && !dq_oe && we_n && re_n,
        "R1", {busy, done, err, rd_valid, cle, ale, dq_oe, we_n, re_n}, 9'b000000011);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && we_n && re_n, "R1", {busy, we_n, re_n}, 3'b011);

    for (int v = 0; v < NV; v++) begin
      busy_at = BAT[v]; busy_len = 10;
      run_op(OPS[v], SEL[v], CNT[v]);
      chk(got_done && !err_at_done, "R14", {got_done, err_at_done}, 2'b10);
      chk(nw == NWE[v], tag(v), nw, NWE[v]);
      for (int k = 0; k < NWE[v] && k < 16; k++)
        chk(wlog[k] == WR[v][k], tag(v), wlog[k], WR[v][k]);
      chk(nr == NRD[v], tag(v), nr, NRD[v]);
      chk(rd_bad == 0, "R10", rd_bad, 0);
      if (NRD[v] > 0) begin
        if (OPS[v] == 2 || OPS[v] == 3) chk(first_re - last_wr >= TWHR, tag(v), first_re - last_wr, TWHR);
        if (OPS[v] == 5) chk(first_re - last_wr >= TRR, "R7", first_re - last_wr, TRR);
        if (OPS[v] == 4 || OPS[v] == 7) chk(first_re - rb_rise >= TRR, tag(v), first_re - rb_rise, TRR);
      end
    end

    busy_at = 0;
    clr_req++;
    @(negedge clk);
    op = 3'd2; rd_count = 9'd3; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    op = 3'd0; start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(nw == 2 && wlog[0] == cw(8'h90) && wlog[1] == aw(8'h00), "R13", nw, 2);
    chk(nr == 3 && !busy, "R13", nr, 3);

    busy_at = 7; busy_len = 100;
    run_op(6, 0, 0);
    chk(got_done && err_at_done, "R12", {got_done, err_at_done}, 2'b11);
    repeat (5) @(negedge clk);
    chk(err && !busy, "R12", {err, busy}, 2'b10);
    for (int k = 0; k < 500 && !rb_n; k++) @(negedge clk);
    busy_at = 0; busy_len = 10;
    run_op(2, 0, 0);
    chk(got_done && !err, "R12", err, 0);
    chk(nr == 0 && first_re < 0, "R11", nr, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule